// File: doc/BRIEF.md
# Reprogrammable Glitch-Free Clock Divider

This block derives a slower clock from one source clock. The division ratio is a word that may change at any time while the clock runs. The divided output never shows a runt pulse or a glitch across a ratio change. Every edge of the output falls on an edge of the source clock. For ratios of two or more, output edges come only from rising source edges. In the pass-through mode, the output also follows the falling source edges.

A control sequencer compares the requested ratio with the ratio currently in use. When the two differ, it runs a fixed procedure:

1. Close a latch-based clock gate, timed to a point where the divided clock is already low.
2. Clear the division counter.
3. Load the new ratio.
4. Let the counter run for a parameterised number of whole new-ratio periods.
5. Reopen the gate, again at a low point of the divided clock.

A busy flag covers the whole procedure. Reset follows the same path from the load step onward. Reset therefore takes whatever ratio is on the input, and the output appears only after the same settling delay.

Top module: `ratio_clk_div`

## Requirements
- R1: One source cycle after `ratioReq` first differs from the ratio in use while idle, `busy` is high. A write of the ratio already in use starts nothing, and `busy` stays low.
- R2: The clock gate only changes state at a source edge where the divided level goes, or stays, low. No high pulse of `clkOut` is cut short, and `clkOut` never has a high or low phase shorter than half a source period. When both the old and the new ratio are 2 or more, every high pulse lasts at least one full source period.
- R3: The division counter is cleared while the gate is closed, before counting restarts.
- R4: The new ratio is loaded into the divider only while the gate is closed, and after the counter clear.
- R5: The gate reopens only after `WAIT_PERIODS` (default 2) whole periods of the new ratio have been counted. For old ratio A and new ratio B (each taken as 1 when 0 or 1), `busy` lasts between 2·B and A+3·B+8 source cycles.
- R6: A ratio of 0 or 1 passes the source clock through, giving a 5 ns period with 2.5 ns high. A ratio N ≥ 2 gives a period of N source cycles, high for floor(N/2) of them.
- R7: `busy` stays high without a break from detection until the gate has reopened. A change that arrives before that point is taken up, and the output ends at the last requested ratio.
- R8: While `rstN` is low, `clkOut` is low and `busy` is high. After release, the divider loads the ratio present on `ratioReq` and opens after the R5 delay.
- R9: Every edge of `clkOut` coincides in time with an edge of `clkIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ratioReq | input | RATIO_W | Requested division ratio (0 and 1 mean divide by one) |
| clkOut | output | 1 | Gated divided clock |
| busy | output | 1 | High while a reconfiguration sequence is in progress |

## Verification
A table drives a run of ratios through the block: even, odd, the two pass-through codes, and large and small steps in each direction. The measured period and high time after each change show whether the division and the floor-rounded duty are right. The busy length separates a correctly counted settling delay from one that is too short or too long. Steps between two ratios of 2 or more tell a cleanly timed gate apart from one that clips a pulse. Directed cases then cover reset loading, an unchanged ratio written again, and new requests that land early and late inside a running sequence.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_GATE,
    ST_CLEAR,
    ST_LOAD,
    ST_WAIT,
    ST_OPEN
  } seqState_t;

  typedef struct packed {
    logic gateEn;
    logic cntClr;
    logic ratioLoad;
  } seqStrobe_t;

endpackage

// File: rtl/divSeqCtrl.sv
module divSeqCtrl
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W      = 8,
  parameter int WAIT_PERIODS = 2
) (
  input  logic               clkIn,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioReq,
  input  logic [RATIO_W-1:0] ratioCur,
  input  logic               gateOn,
  input  logic               periodTick,
  output seqStrobe_t         strobes,
  output logic               busy
);

  localparam int WAIT_W = (WAIT_PERIODS < 2) ? 1 : $clog2(WAIT_PERIODS);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_PERIODS - 1);

  seqState_t          state, stateNext;
  logic [WAIT_W-1:0]  waitCnt;
  logic               mismatch;

  assign mismatch = (ratioReq != ratioCur);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:   if (mismatch) stateNext = ST_GATE;
      ST_GATE:  if (!gateOn) stateNext = ST_CLEAR;
      ST_CLEAR: stateNext = ST_LOAD;
      ST_LOAD:  stateNext = ST_WAIT;
      ST_WAIT: begin
        if (mismatch) stateNext = ST_GATE;
        else if (periodTick && waitCnt == WAIT_LAST) stateNext = ST_OPEN;
      end
      ST_OPEN: begin
        if (mismatch) stateNext = ST_GATE;
        else if (gateOn) stateNext = ST_RUN;
      end
      default: stateNext = ST_LOAD;
    endcase
  end

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_LOAD;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_LOAD) waitCnt <= '0;
      else if (state == ST_WAIT && periodTick && waitCnt != WAIT_LAST)
        waitCnt <= waitCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.gateEn    = (state == ST_RUN) || (state == ST_OPEN);
    strobes.cntClr    = (state == ST_CLEAR);
    strobes.ratioLoad = (state == ST_LOAD);
    busy              = (state != ST_RUN);
  end

endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic               clkIn,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioReq,
  input  seqStrobe_t         strobes,
  output logic [RATIO_W-1:0] ratioCur,
  output logic               gateOn,
  output logic               divLevel,
  output logic               bypass,
  output logic               periodTick,
  output logic               fallNext,
  output logic               clkOut
);

  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt, cntNext, half;
  logic               periodEnd;
  logic               gateQ;

  assign bypass     = (ratioCur <= ONE);
  assign half       = ratioCur >> 1;
  assign periodEnd  = (cnt == ratioCur - ONE);
  assign periodTick = bypass || periodEnd;
  // next edge drives the divided level low (or it carries no pulse at all)
  assign fallNext   = bypass || (cnt == half - ONE);
  assign cntNext    = periodEnd ? '0 : cnt + ONE;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      ratioCur <= '0;
      cnt      <= '0;
      divLevel <= 1'b0;
      gateOn   <= 1'b0;
    end else begin
      if (strobes.ratioLoad) ratioCur <= ratioReq;
      if (strobes.cntClr || strobes.ratioLoad || bypass) begin
        cnt      <= '0;
        divLevel <= 1'b0;
      end else begin
        cnt      <= cntNext;
        divLevel <= (cntNext < half);
      end
      if (fallNext) gateOn <= strobes.gateEn;
    end
  end

  // enable latch: transparent only while the source clock is low
  always_latch begin
    if (!rstN)       gateQ = 1'b0;
    else if (!clkIn) gateQ = gateOn;
  end

  assign clkOut = gateQ & (bypass ? clkIn : divLevel);

endmodule

// File: rtl/ratio_clk_div.sv
module ratio_clk_div
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W      = 8,
  parameter int WAIT_PERIODS = 2
) (
  input  logic               clkIn,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioReq,
  output logic               clkOut,
  output logic               busy
);

  seqStrobe_t         strobes;
  logic [RATIO_W-1:0] ratioCur;
  logic               gateOn, divLevel, bypass, periodTick, fallNext;

  divSeqCtrl #(.RATIO_W(RATIO_W), .WAIT_PERIODS(WAIT_PERIODS)) u_ctrl (
    .clkIn(clkIn), .rstN(rstN), .ratioReq(ratioReq), .ratioCur(ratioCur),
    .gateOn(gateOn), .periodTick(periodTick), .strobes(strobes), .busy(busy)
  );

  divDatapath #(.RATIO_W(RATIO_W)) u_dp (
    .clkIn(clkIn), .rstN(rstN), .ratioReq(ratioReq), .strobes(strobes),
    .ratioCur(ratioCur), .gateOn(gateOn), .divLevel(divLevel), .bypass(bypass),
    .periodTick(periodTick), .fallNext(fallNext), .clkOut(clkOut)
  );

endmodule

// File: rtl/divCheck.sv
module divCheck
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input logic               clkIn,
  input logic               rstN,
  input logic [RATIO_W-1:0] ratioReq,
  input logic [RATIO_W-1:0] ratioCur,
  input logic               busy,
  input logic               gateOn,
  input logic               divLevel,
  input logic               bypass,
  input seqStrobe_t         strobes
);

  // R1
  change_detect_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    (!busy && ratioReq != ratioCur) |=> busy);

  // R1
  steady_idle_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    (!busy && ratioReq == ratioCur) |=> !busy);

  // R2
  gate_open_safe_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    $rose(gateOn) |-> (bypass || !divLevel));

  // R2
  gate_close_safe_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    $fell(gateOn) |-> (bypass || !divLevel));

  // R3
  clear_gated_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    strobes.cntClr |-> !gateOn);

  // R4
  load_gated_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    strobes.ratioLoad |-> !gateOn);

  // R4
  ratio_swap_gated_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    !$stable(ratioCur) |-> !gateOn);

  // R5
  open_in_seq_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    $rose(gateOn) |-> busy);

  // R7
  busy_release_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    $fell(busy) |-> gateOn);

endmodule

bind ratio_clk_div divCheck #(.RATIO_W(RATIO_W)) u_divCheck (
  .clkIn(clkIn), .rstN(rstN), .ratioReq(ratioReq), .ratioCur(ratioCur),
  .busy(busy), .gateOn(gateOn), .divLevel(divLevel), .bypass(bypass),
  .strobes(strobes)
);

// File: tb/ratio_clk_div_bench.sv
module ratio_clk_div_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NVEC = 9;
  localparam int VEC_RATIO [NVEC] = '{4, 2, 3, 1, 0, 5, 8, 2, 7};
  localparam int VEC_PER   [NVEC] = '{4, 2, 3, 1, 1, 5, 8, 2, 7};  // source cycles
  localparam int VEC_HIH   [NVEC] = '{4, 2, 2, 1, 1, 4, 8, 2, 6};  // high, half cycles

  logic       clkIn = 1'b0;
  logic       rstN  = 1'b0;
  logic [7:0] ratioReq = 8'd6;
  logic       clkOut, busy;

  int checks = 0, errors = 0;
  int glitchCnt = 0, shortHighCnt = 0, offEdgeCnt = 0;
  bit done = 1'b0;
  realtime tRise = 0.0, tFall = 0.0;

  ratio_clk_div u_ratio_clk_div (
    .clkIn(clkIn), .rstN(rstN), .ratioReq(ratioReq), .clkOut(clkOut), .busy(busy)
  );

  initial forever #2.5 clkIn = ~clkIn;

  function automatic bit onSrcEdge(realtime t);
    real r;
    r = t / 2.5;
    return (r - $floor(r + 0.5) < 0.01) && ($floor(r + 0.5) - r < 0.01);
  endfunction

  // R9 / R2 monitors
  always @(posedge clkOut) if (rstN) begin
    if (!onSrcEdge($realtime)) offEdgeCnt++;
    if (tFall > 0.0 && $realtime - tFall < 2.0) glitchCnt++;
    tRise = $realtime;
  end

  always @(negedge clkOut) if (rstN) begin
    if (!onSrcEdge($realtime)) offEdgeCnt++;
    if ($realtime - tRise < 2.0) glitchCnt++;
    if ($realtime - tRise < 4.0) shortHighCnt++;
    tFall = $realtime;
  end

  task automatic chkInt(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkRange(string req, string what, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic chkReal(string req, string what, real act, real exp);
    checks++;
    if (act - exp > 0.01 || exp - act > 0.01) begin
      errors++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic waitIdle(output int cyc, output bit gap);
    cyc = 0;
    gap = 1'b0;
    while (busy && cyc < 2000) begin
      @(negedge clkIn);
      cyc++;
    end
  endtask

  // R6: period and high time of the running output
  task automatic measure(string req, int perCyc, int hiHalf);
    realtime t0, t1, t2;
    repeat (2) @(negedge clkIn);
    @(posedge clkOut); t0 = $realtime;
    @(negedge clkOut); t1 = $realtime;
    @(posedge clkOut); t2 = $realtime;
    chkReal(req, "period ns", t2 - t0, perCyc * 5.0);
    chkReal(req, "high ns", t1 - t0, hiHalf * 2.5);
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int cyc, oldEff, newEff, prevRatio;
    bit gap;

    // R8: reset state
    repeat (4) @(negedge clkIn);
    chkInt("R8", "clkOut in reset", int'(clkOut), 0);
    chkInt("R8", "busy in reset", int'(busy), 1);
    rstN = 1'b1;
    waitIdle(cyc, gap);
    chkRange("R8", "settle cycles after reset", cyc, 12, 6 + 3 * 6 + 8);
    measure("R8", 6, 6);
    prevRatio = 6;

    // table walk: R1, R5, R6, R2, R7
    for (int i = 0; i < NVEC; i++) begin
      oldEff = (prevRatio <= 1) ? 1 : prevRatio;
      newEff = (VEC_RATIO[i] <= 1) ? 1 : VEC_RATIO[i];
      @(negedge clkIn);
      ratioReq = 8'(VEC_RATIO[i]);
      @(negedge clkIn);
      chkInt("R1", "busy after change", int'(busy), 1);
      shortHighCnt = 0;
      waitIdle(cyc, gap);
      chkRange("R5", "busy cycles", cyc + 1, 2 * newEff, oldEff + 3 * newEff + 8);
      measure("R6", VEC_PER[i], VEC_HIH[i]);
      if (prevRatio >= 2 && VEC_RATIO[i] >= 2)
        chkInt("R2", "clipped high pulses", shortHighCnt, 0);
      prevRatio = VEC_RATIO[i];
    end

    // R1: writing the ratio already in use starts nothing
    begin
      int busySeen = 0;
      @(negedge clkIn);
      ratioReq = 8'd7;
      for (int k = 0; k < 10; k++) begin
        @(negedge clkIn);
        busySeen += int'(busy);
      end
      chkInt("R1", "busy on unchanged ratio", busySeen, 0);
    end

    // R7: early change inside a running sequence
    begin
      int drops = 0;
      @(negedge clkIn);
      ratioReq = 8'd3;
      repeat (3) begin
        @(negedge clkIn);
        if (!busy) drops++;
      end
      ratioReq = 8'd5;
      waitIdle(cyc, gap);
      chkInt("R7", "busy gaps early change", drops, 0);
      shortHighCnt = 0;
      measure("R7", 5, 4);
      chkInt("R2", "clipped high pulses early change", shortHighCnt, 0);
    end

    // R7: late change, during the settling count of ratio 8
    begin
      int drops = 0;
      @(negedge clkIn);
      ratioReq = 8'd8;
      repeat (12) begin
        @(negedge clkIn);
        if (!busy) drops++;
      end
      chkInt("R7", "busy gaps late change", drops, 0);
      ratioReq = 8'd2;
      @(negedge clkIn);
      chkInt("R7", "busy held after late change", int'(busy), 1);
      waitIdle(cyc, gap);
      measure("R7", 2, 2);
    end

    // R2 / R9 summaries of the edge monitors
    chkInt("R2", "runt phases", glitchCnt, 0);
    chkInt("R9", "edges off source grid", offEdgeCnt, 0);

    finishRun();
  end

endmodule